// File: doc/BRIEF.md
# Interrupt Request Trigger Latch

This block turns a set of raw interrupt request wires into a register of pending requests. Each line works in one of two trigger modes, chosen by a mode register: in edge mode a low-to-high transition of the wire raises the pending bit, and in level mode the pending bit tracks the wire. To see edges, the block keeps the level that each wire had on the previous clock. The interrupt controller that sits downstream reads the pending vector and handles priority, masking and in-service tracking.

The mode register is written and read over a byte-wide bus port. Each instance has a fixed write mask, so on some lines the mode is tied to edge. The controller pulses a per-line clear when it acknowledges a request. It pulses a controller-initialise input when it is reprogrammed. Initialisation empties the pending and last-level records and leaves the mode register as it was.

The flow for each line is named as follows. The mode decode is `TRIG_EDGE` or `TRIG_LEVEL`. From the mode, the wire, the stored last level and the clear, the line picks one of three events:
- `EVT_SET`: the line is in level mode with the wire high, or in edge mode with a rising edge.
- `EVT_CLEAR`: the line is in level mode with the wire low, or in edge mode with the clear present and no rising edge.
- `EVT_HOLD`: any other case.

Initialisation takes priority over all three events.

Top module: `irq_trigger_latch`

## Requirements
- R1: After reset, `pending` reads 0x00 and `bus_rdata` reads 0x00.
- R2: A cycle with `bus_wr` high stores `bus_wdata` AND `MODE_WMASK`. The default mask is 0xF8, so lines 0 to 2 stay edge. From the next cycle `bus_rdata` returns the stored value. Bit i of the mode register set to 1 selects level mode for line i, and 0 selects edge mode.
- R3: A line in level mode has its pending bit equal, one clock later, to the wire level it sampled.
- R4: A line in edge mode sets its pending bit one clock after a sample where the wire is high and the previous sample was low.
- R5: A line in edge mode that holds high, or that falls, leaves its pending bit unchanged.
- R6: An acknowledge clear on an edge-mode line clears its pending bit one clock later.
- R7: An acknowledge clear on a level-mode line has no effect on its pending bit.
- R8: A rising edge and an acknowledge clear of the same edge-mode line in one cycle leave the pending bit set.
- R9: `ctrl_init` clears all pending bits and all last-level records one clock later and keeps the mode register. An edge line whose wire stays high through initialisation sets again on the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Raw request wires, sampled each clock |
| ack_clr | input | NUM_LINES | Per-line acknowledge clear |
| ctrl_init | input | 1 | Controller initialise pulse |
| bus_wr | input | 1 | Mode register write strobe |
| bus_wdata | input | NUM_LINES | Mode register write data |
| bus_rdata | output | NUM_LINES | Current mode register value |
| pending | output | NUM_LINES | Pending request vector |

## Verification
Two functions can act on the same edge-mode line in one cycle: setting it on a rising edge and clearing it on an acknowledge. The bench provokes this by raising a wire while the same line's clear is asserted. It then checks that the pending bit reads 1 on the next cycle. A second overlap is initialisation arriving while a wire is high. The bench checks that pending is zero first and that the edge fires again on the following sample, which shows that the last-level record was wiped.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef enum logic [1:0] {
        EVT_HOLD  = 2'd0,
        EVT_SET   = 2'd1,
        EVT_CLEAR = 2'd2
    } line_evt_e;

endpackage

// File: rtl/trig_mode_reg.sv
module trig_mode_reg #(
    parameter int                   NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] WMASK     = 8'hF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] mode_o
);

    logic [NUM_LINES-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wr_data & WMASK;
        end
    end

    assign mode_o = mode_q;

    // R2
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_q == ($past(wr_data) & WMASK)));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q));

endmodule

// File: rtl/req_line_cell.sv
module req_line_cell
    import irq_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  trig_mode_e mode,
    input  logic       req_in,
    input  logic       ack,
    output logic       pend_o
);

    logic      pend_q;
    logic      last_q;
    line_evt_e evt;

    always_comb begin
        evt = EVT_HOLD;
        unique case (mode)
            TRIG_LEVEL: evt = req_in ? EVT_SET : EVT_CLEAR;
            TRIG_EDGE: begin
                if (req_in && !last_q) begin
                    evt = EVT_SET;
                end else if (ack) begin
                    evt = EVT_CLEAR;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            last_q <= 1'b0;
        end else if (init) begin
            pend_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            last_q <= req_in;
            unique case (evt)
                EVT_SET:   pend_q <= 1'b1;
                EVT_CLEAR: pend_q <= 1'b0;
                EVT_HOLD:  pend_q <= pend_q;
                default:   pend_q <= pend_q;
            endcase
        end
    end

    assign pend_o = pend_q;

    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && mode == TRIG_LEVEL) |=> (pend_q == $past(req_in)));

    // R4
    edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && mode == TRIG_EDGE && req_in && !last_q) |=> pend_q);

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && mode == TRIG_EDGE && !ack && !(req_in && !last_q)) |=> $stable(pend_q));

    // R6
    edge_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && mode == TRIG_EDGE && ack && !(req_in && !last_q)) |=> !pend_q);

    // R9
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (!pend_q && !last_q));

endmodule

// File: rtl/irq_trigger_latch.sv
module irq_trigger_latch
    import irq_latch_pkg::*;
#(
    parameter int                   NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0] MODE_WMASK = 8'hF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] ack_clr,
    input  logic                 ctrl_init,
    input  logic                 bus_wr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic [NUM_LINES-1:0] pending
);

    logic [NUM_LINES-1:0] mode_vec;

    trig_mode_reg #(
        .NUM_LINES (NUM_LINES),
        .WMASK     (MODE_WMASK)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_data (bus_wdata),
        .mode_o  (mode_vec)
    );

    assign bus_rdata = mode_vec;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        req_line_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .init   (ctrl_init),
            .mode   (trig_mode_e'(mode_vec[i])),
            .req_in (irq_in[i]),
            .ack    (ack_clr[i]),
            .pend_o (pending[i])
        );
    end

    // R7
    level_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_init && bus_rdata[NUM_LINES-1] && ack_clr[NUM_LINES-1] && irq_in[NUM_LINES-1])
            |=> pending[NUM_LINES-1]);

    // R2
    mask_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bus_rdata & ~MODE_WMASK) == '0));

endmodule

// File: tb/irq_trigger_latch_tb.sv
module irq_trigger_latch_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic [7:0] ack_clr = '0;
    logic       ctrl_init = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_trigger_latch #(.NUM_LINES(8), .MODE_WMASK(8'hF8)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .ack_clr   (ack_clr),
        .ctrl_init (ctrl_init),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pending   (pending)
    );

    // Vector fields: {irq_in, ack_clr, init (bit 0 of byte), expected pending}.
    // Mode register is 0xF8: lines 0..2 edge, lines 3..7 level.
    localparam int NVEC = 14;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 8'h00, 8'h00},  // R3 idle
        {8'hFF, 8'h00, 8'h00, 8'hFF},  // R3 R4 all rise
        {8'hFF, 8'hFF, 8'h00, 8'hF8},  // R6 R7 ack while held high
        {8'hFF, 8'h00, 8'h00, 8'hF8},  // R5 held high no re-set
        {8'h00, 8'h00, 8'h00, 8'h00},  // R3 level drop
        {8'h05, 8'h00, 8'h00, 8'h05},  // R4 lines 0 and 2 rise
        {8'h00, 8'h00, 8'h00, 8'h05},  // R5 falling keeps pending
        {8'h01, 8'h01, 8'h00, 8'h05},  // R8 rise plus ack, set wins
        {8'h00, 8'h04, 8'h00, 8'h01},  // R6 ack line 2
        {8'h18, 8'h00, 8'h00, 8'h19},  // R3 level lines 3 and 4
        {8'h18, 8'h18, 8'h00, 8'h19},  // R7 ack on level lines ignored
        {8'h02, 8'h00, 8'h01, 8'h00},  // R9 init clears
        {8'h02, 8'h00, 8'h00, 8'h02},  // R9 last level wiped, edge fires again
        {8'h00, 8'h02, 8'h00, 8'h00}   // R6 final ack
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] in_v, input logic [7:0] ack_v, input logic init_v);
        @(negedge clk);
        irq_in    = in_v;
        ack_clr   = ack_v;
        ctrl_init = init_v;
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [7:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 pending", pending, 8'h00);
        check("R1 mode", bus_rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        bus_write(8'hA5);
        check("R2 masked write", bus_rdata, 8'hA0);
        bus_write(8'h07);
        check("R2 masked-off bits", bus_rdata, 8'h00);
        bus_write(8'hFF);
        check("R2 full write", bus_rdata, 8'hF8);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][31:24], VEC[i][23:16], VEC[i][8]);
            check($sformatf("vector %0d", i), pending, VEC[i][7:0]);
        end
        check("R9 mode kept after init", bus_rdata, 8'hF8);

        // R8 directed: rise and ack on line 1, then release
        apply(8'h02, 8'h02, 1'b0);
        check("R8 set wins", pending, 8'h02);
        apply(8'h00, 8'h02, 1'b0);
        check("R6 clear after", pending, 8'h00);

        // R3 switch line 0..2 to edge, line 7 level held high then init
        apply(8'h80, 8'h00, 1'b0);
        check("R3 level line 7", pending, 8'h80);
        apply(8'h80, 8'h00, 1'b1);
        check("R9 init while high", pending, 8'h00);
        apply(8'h80, 8'h80, 1'b0);
        check("R7 level resumes", pending, 8'h80);

        // R2: after mode cleared, level line becomes edge; ack then clears
        bus_write(8'h00);
        check("R2 mode cleared", bus_rdata, 8'h00);
        apply(8'h80, 8'h80, 1'b0);
        check("R6 ack edge line 7", pending, 8'h00);
        apply(8'h80, 8'h00, 1'b0);
        check("R5 held high edge", pending, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule